// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block is the shift stage of a fixed-point datapath. It takes a 16-bit word, sets it into one half of a 32-bit frame, and moves it left or right by a signed count. Logical shifts fill with zeros. Arithmetic shifts keep the sign. It can also count how many copies of the sign bit sit below the most significant bit (the redundant sign bits). It uses that count to normalize the word, or shifts a word right by a given exponent to denormalize it.

Across a series of words it keeps a running block exponent: the smallest redundant-sign count seen since the last clear. Software uses this to scale a whole buffer by one common amount for block floating-point work. The same holds for multiword values built from a high and a low half.

An operation is issued in a cycle by driving the op code with its operands. Results appear on the registered outputs one clock later. Outputs that an operation does not produce keep their previous values.

Top module: `shift_norm_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `result` reads 0, `exp_out` reads 0 and `blk_exp` reads 15, until an operation changes them.
- R2: Every operation updates the outputs at the first rising clock edge after it is applied. With `place_hi`=1 the word takes frame bits 31:16 and bits 15:0 are zero. With `place_hi`=0 the word takes bits 15:0. Bits 31:16 are then zero for logical shifts, and a copy of input bit 15 for all other operations.
- R3: Op code 0 (logical shift) reads `amount` as 8-bit two's complement. A positive value shifts the frame left, a negative one shifts it right by its magnitude, and vacated bits are zero. `exp_out` and `blk_exp` are unchanged.
- R4: Op code 1 (arithmetic shift) uses the same amount rules, but right shifts fill with frame bit 31.
- R5: With an amount magnitude of 32 or more (down to -128), op code 0 gives 0 and op code 1 gives 0 for left shifts. For right shifts, op code 1 fills all 32 bits with frame bit 31.
- R6: Op code 2 (derive exponent) sets `exp_out` to the number of bits below bit 15 that equal bit 15 before the first bit that differs, from 0 to 15. An input of 0x0000 or 0xFFFF gives 15. `result` is unchanged.
- R7: Op code 3 (normalize) shifts the sign-extended frame left by the input's redundant-sign count and writes that count to `exp_out`. For a placed-high input other than 0x0000 and 0xFFFF, result bits 31 and 30 then differ.
- R8: Op code 4 (denormalize) reads `amount` as unsigned 0 to 255 and shifts the sign-extended frame right arithmetically. Counts of 32 or more give all copies of frame bit 31. `exp_out` is unchanged.
- R9: Op code 5 (block exponent) sets `exp_out` to the input's redundant-sign count and lowers `blk_exp` to that count if it is smaller. `result` is unchanged. No other op code changes `blk_exp`.
- R10: `blk_clear`=1 loads `blk_exp` with 15 at the next edge. This wins over op code 5 in the same cycle, while the rest of that operation still takes effect.
- R11: Op codes 6 and 7 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code |
| data_in | input | 16 | Input word |
| amount | input | 8 | Shift count (signed for op 0/1, unsigned for op 4) |
| place_hi | input | 1 | 1 places the word in the high half of the frame |
| blk_clear | input | 1 | Reloads the block exponent with 15 |
| result | output | 32 | Shifted frame |
| exp_out | output | 4 | Last derived exponent |
| blk_exp | output | 4 | Running block exponent |

## Verification
The hardest cases to reach are the saturation edges of the shift count. These are the amounts 31, 32, -31, -32 and -128, where the magnitude of -128 cannot be held in eight bits. The stimulus therefore sweeps every one of the 256 amount codes for both shift kinds, both placements and several sign patterns. The block exponent is harder still, because its value depends on history. Runs of words with falling and rising counts are issued with clears between them, including a clear in the same cycle as a block update, and are interleaved with operations that must leave it alone.

// File: rtl/shift_norm_pkg.sv
package shift_norm_pkg;
    localparam logic [2:0] OP_LSH    = 3'd0;
    localparam logic [2:0] OP_ASH    = 3'd1;
    localparam logic [2:0] OP_EXP    = 3'd2;
    localparam logic [2:0] OP_NORM   = 3'd3;
    localparam logic [2:0] OP_DENORM = 3'd4;
    localparam logic [2:0] OP_BLK    = 3'd5;
endpackage

// File: rtl/sign_run_count.sv
module sign_run_count #(
    parameter int W    = 16,
    parameter int CW   = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);
    logic run;

    always_comb begin
        count = '0;
        run   = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (word[i] == word[W-1])) begin
                count = CW'(count + 1'b1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/frame_place.sv
module frame_place #(
    parameter int W = 16
) (
    input  logic [W-1:0]   word,
    input  logic           upper,
    input  logic           extend,
    output logic [2*W-1:0] frame
);
    always_comb begin
        if (upper) begin
            frame = {word, {W{1'b0}}};
        end else begin
            frame = {{W{extend & word[W-1]}}, word};
        end
    end
endmodule

// File: rtl/log_barrel.sv
module log_barrel #(
    parameter int FW    = 32,
    parameter int MAG_W = 9,
    localparam int LOG  = $clog2(FW)
) (
    input  logic [FW-1:0]    frame,
    input  logic             to_left,
    input  logic             arith,
    input  logic [MAG_W-1:0] mag,
    output logic [FW-1:0]    shifted
);
    logic [FW-1:0] lst [0:LOG];
    logic [FW-1:0] rst [0:LOG];
    logic          fill;
    logic          sat;

    assign fill   = arith & frame[FW-1];
    assign sat    = |mag[MAG_W-1:LOG];
    assign lst[0] = frame;
    assign rst[0] = frame;

    for (genvar k = 0; k < LOG; k++) begin : g_stage
        localparam int S = 1 << k;
        assign lst[k+1] = mag[k] ? {lst[k][FW-1-S:0], {S{1'b0}}} : lst[k];
        assign rst[k+1] = mag[k] ? {{S{fill}}, rst[k][FW-1:S]}   : rst[k];
    end

    always_comb begin
        if (to_left) begin
            shifted = sat ? '0 : lst[LOG];
        end else begin
            shifted = sat ? {FW{fill}} : rst[LOG];
        end
    end
endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 8,
    localparam int FRAME_W = 2 * DATA_W,
    localparam int EXP_W   = $clog2(DATA_W),
    localparam int MAG_W   = AMT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  data_in,
    input  logic [AMT_W-1:0]   amount,
    input  logic               place_hi,
    input  logic               blk_clear,
    output logic [FRAME_W-1:0] result,
    output logic [EXP_W-1:0]   exp_out,
    output logic [EXP_W-1:0]   blk_exp
);
    import shift_norm_pkg::*;

    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(DATA_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] res;
        logic [EXP_W-1:0]   expo;
        logic [EXP_W-1:0]   blk;
    } state_t;

    state_t             st_d, st_q;
    logic [EXP_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] shifted;
    logic               extend;
    logic               to_left;
    logic               arith;
    logic [MAG_W-1:0]   mag;
    logic [MAG_W-1:0]   amt_wide;

    sign_run_count #(.W(DATA_W), .CW(EXP_W)) u_count (
        .word  (data_in),
        .count (cnt)
    );

    frame_place #(.W(DATA_W)) u_place (
        .word   (data_in),
        .upper  (place_hi),
        .extend (extend),
        .frame  (frame)
    );

    log_barrel #(.FW(FRAME_W), .MAG_W(MAG_W)) u_barrel (
        .frame   (frame),
        .to_left (to_left),
        .arith   (arith),
        .mag     (mag),
        .shifted (shifted)
    );

    assign extend   = (op != OP_LSH);
    assign arith    = (op != OP_LSH);
    assign amt_wide = {amount[AMT_W-1], amount};

    always_comb begin
        to_left = 1'b1;
        mag     = '0;
        unique case (op)
            OP_LSH, OP_ASH: begin
                to_left = ~amount[AMT_W-1];
                mag     = amount[AMT_W-1] ? MAG_W'({MAG_W{1'b0}} - amt_wide) : amt_wide;
            end
            OP_NORM: begin
                to_left = 1'b1;
                mag     = MAG_W'(cnt);
            end
            OP_DENORM: begin
                to_left = 1'b0;
                mag     = {1'b0, amount};
            end
            default: begin
                to_left = 1'b1;
                mag     = '0;
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LSH, OP_ASH, OP_DENORM: begin
                st_d.res = shifted;
            end
            OP_NORM: begin
                st_d.res  = shifted;
                st_d.expo = cnt;
            end
            OP_EXP: begin
                st_d.expo = cnt;
            end
            OP_BLK: begin
                st_d.expo = cnt;
                if (cnt < st_q.blk) begin
                    st_d.blk = cnt;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
        if (blk_clear) begin
            st_d.blk = EXP_MAX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.res  <= '0;
            st_q.expo <= '0;
            st_q.blk  <= EXP_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign exp_out = st_q.expo;
    assign blk_exp = st_q.blk;
endmodule

// File: rtl/shift_norm_unit_chk.sv
module shift_norm_unit_chk #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 8,
    localparam int FRAME_W = 2 * DATA_W,
    localparam int EXP_W   = $clog2(DATA_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         op,
    input logic [DATA_W-1:0]  data_in,
    input logic [AMT_W-1:0]   amount,
    input logic               place_hi,
    input logic               blk_clear,
    input logic [FRAME_W-1:0] result,
    input logic [EXP_W-1:0]   exp_out,
    input logic [EXP_W-1:0]   blk_exp
);
    localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(DATA_W - 1);

    logic big_amt;
    assign big_amt = ($signed(amount) >= 32) || ($signed(amount) <= -32);

    AST_BLK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clear |=> (blk_exp == EXP_MAX)); // R10

    AST_BLK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && !blk_clear) |=> (blk_exp <= $past(blk_exp))); // R9

    AST_BLK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd5 && !blk_clear) |=> $stable(blk_exp)); // R9

    AST_EXP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |=> $stable(result)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 3'd6) |=> ($stable(result) && $stable(exp_out))); // R11

    AST_LSH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0 && big_amt) |=> (result == '0)); // R5

    AST_NORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && place_hi && data_in != '0 && data_in != '1)
        |=> (result[FRAME_W-1] != result[FRAME_W-2])); // R7
endmodule

bind shift_norm_unit shift_norm_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .data_in   (data_in),
    .amount    (amount),
    .place_hi  (place_hi),
    .blk_clear (blk_clear),
    .result    (result),
    .exp_out   (exp_out),
    .blk_exp   (blk_exp)
);

// File: tb/shift_norm_unit_test.sv
module shift_norm_unit_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd6;
    logic [15:0] data_in = '0;
    logic [7:0]  amount = '0;
    logic        place_hi = 1'b0;
    logic        blk_clear = 1'b0;
    logic [31:0] result;
    logic [3:0]  exp_out;
    logic [3:0]  blk_exp;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_res = '0;
    logic [3:0]  m_exp = '0;
    logic [3:0]  m_blk = 4'd15;

    always #(PERIOD/2) clk = ~clk;

    shift_norm_unit uut (
        .clk(clk), .rst_n(rst_n), .op(op), .data_in(data_in), .amount(amount),
        .place_hi(place_hi), .blk_clear(blk_clear),
        .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
    );

    function automatic int rsb(logic [15:0] d);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (d[i] == d[15]) n++;
            else break;
        end
        return n;
    endfunction

    function automatic logic [31:0] place(logic [15:0] d, logic hi, logic sx);
        if (hi) return {d, 16'h0000};
        if (sx && d[15]) return {16'hFFFF, d};
        return {16'h0000, d};
    endfunction

    function automatic logic [31:0] ref_shift(logic [31:0] f, logic ar, logic left, int mag);
        logic [31:0] v = f;
        if (left) begin
            if (mag >= 32) return 32'h0;
            for (int i = 0; i < mag; i++) v = {v[30:0], 1'b0};
            return v;
        end
        if (mag >= 32) return (ar && f[31]) ? 32'hFFFF_FFFF : 32'h0;
        for (int i = 0; i < mag; i++) v = {ar & f[31], v[31:1]};
        return v;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [15:0] d, input logic [7:0] a,
                        input logic hi, input logic clr, input string tag);
        int c;
        int sa;
        @(negedge clk);
        op = o; data_in = d; amount = a; place_hi = hi; blk_clear = clr;
        c = rsb(d);
        sa = int'($signed(a));
        case (o)
            3'd0: m_res = ref_shift(place(d, hi, 1'b0), 1'b0, sa >= 0, (sa >= 0) ? sa : -sa);
            3'd1: m_res = ref_shift(place(d, hi, 1'b1), 1'b1, sa >= 0, (sa >= 0) ? sa : -sa);
            3'd2: m_exp = 4'(c);
            3'd3: begin
                m_res = ref_shift(place(d, hi, 1'b1), 1'b1, 1'b1, c);
                m_exp = 4'(c);
            end
            3'd4: m_res = ref_shift(place(d, hi, 1'b1), 1'b1, 1'b0, int'(a));
            3'd5: begin
                m_exp = 4'(c);
                if (c < int'(m_blk)) m_blk = 4'(c);
            end
            default: ;
        endcase
        if (clr) m_blk = 4'd15;
        @(posedge clk);
        #1;
        check(tag, "result", result, m_res);
        check(tag, "exp_out", {28'h0, exp_out}, {28'h0, m_exp});
        check(tag, "blk_exp", {28'h0, blk_exp}, {28'h0, m_blk});
    endtask

    initial begin
        #(PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pats [6] = '{16'h0001, 16'h8000, 16'h7FFF, 16'hA5C3, 16'hFFFF, 16'h1234};
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1", "result", result, 32'h0);
        check("R1", "exp_out", {28'h0, exp_out}, 32'h0);
        check("R1", "blk_exp", {28'h0, blk_exp}, 32'd15);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "result", result, 32'h0);
        check("R1", "blk_exp", {28'h0, blk_exp}, 32'd15);

        // R2: placement with zero shift, one-cycle update
        step(3'd0, 16'h8123, 8'd0, 1'b1, 1'b0, "R2");
        step(3'd0, 16'h8123, 8'd0, 1'b0, 1'b0, "R2");
        step(3'd1, 16'h8123, 8'd0, 1'b0, 1'b0, "R2");
        step(3'd1, 16'h8123, 8'd0, 1'b1, 1'b0, "R2");

        // R3 R4 R5: full amount sweep
        foreach (pats[p]) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int o = 0; o < 2; o++) begin
                    for (int a = -128; a < 128; a++) begin
                        string t;
                        if (a >= 32 || a <= -32) t = "R5";
                        else if (o == 0) t = "R3";
                        else t = "R4";
                        step(3'(o), pats[p], 8'(a), 1'(hi), 1'b0, t);
                    end
                end
            end
        end

        // R6: every input word
        step(3'd2, 16'h0000, 8'd0, 1'b0, 1'b0, "R6");
        step(3'd2, 16'hFFFF, 8'd0, 1'b0, 1'b0, "R6");
        for (int d = 0; d < 65536; d++) step(3'd2, 16'(d), 8'(d), 1'(d & 1), 1'b0, "R6");

        // R7: normalize sweep
        for (int d = 0; d < 65536; d += 37) begin
            step(3'd3, 16'(d), 8'd0, 1'b1, 1'b0, "R7");
            step(3'd3, 16'(d), 8'd0, 1'b0, 1'b0, "R7");
        end
        step(3'd3, 16'h0000, 8'd0, 1'b1, 1'b0, "R7");
        step(3'd3, 16'hFFFF, 8'd0, 1'b1, 1'b0, "R7");

        // R8: denormalize, unsigned counts
        foreach (pats[p]) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int a = 0; a < 256; a++) step(3'd4, pats[p], 8'(a), 1'(hi), 1'b0, "R8");
            end
        end

        // R9: block exponent runs
        step(3'd0, 16'h0000, 8'd0, 1'b0, 1'b1, "R10");
        step(3'd5, 16'h0100, 8'd0, 1'b0, 1'b0, "R9");
        step(3'd5, 16'h0003, 8'd0, 1'b0, 1'b0, "R9");
        step(3'd1, 16'h0001, 8'd3, 1'b0, 1'b0, "R9");
        step(3'd5, 16'h0FFF, 8'd0, 1'b0, 1'b0, "R9");
        step(3'd2, 16'h0000, 8'd0, 1'b0, 1'b0, "R9");
        step(3'd5, 16'hE000, 8'd0, 1'b0, 1'b0, "R9");
        step(3'd5, 16'hFFFF, 8'd0, 1'b0, 1'b0, "R9");
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(3'(i % 6), lf >> (i % 13), 8'(lf), lf[0], (i % 50) == 49, "R9");
        end

        // R10: clear wins over block update
        step(3'd5, 16'h4000, 8'd0, 1'b0, 1'b0, "R10");
        step(3'd5, 16'h4000, 8'd0, 1'b0, 1'b1, "R10");
        step(3'd5, 16'h0040, 8'd0, 1'b0, 1'b0, "R10");
        step(3'd3, 16'h0100, 8'd0, 1'b0, 1'b1, "R10");

        // R11: reserved codes change nothing
        step(3'd1, 16'h9F00, 8'hFC, 1'b1, 1'b0, "R11");
        step(3'd5, 16'h0F00, 8'd0, 1'b0, 1'b0, "R11");
        for (int o = 6; o < 8; o++) begin
            step(3'(o), 16'h0001, 8'd4, 1'b1, 1'b0, "R11");
            step(3'(o), 16'h8000, 8'hF0, 1'b0, 1'b0, "R11");
            step(3'(o), 16'h0000, 8'd31, 1'b0, 1'b0, "R11");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule